// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of procedure returns at the decode stage. It sits next to the static branch predictor. When the decoder sees a procedure call, it pushes the address the call will return to. When the decoder sees an unconditional return, the block supplies the most recently pushed address in the same cycle, so that fetch can be redirected. It then drops that entry. A return that carries a condition gets no prediction, and it leaves the stack as it was.

The storage is a ring of three address slots with a top pointer and an occupancy count. A fourth push without an intervening pop wraps around and overwrites the oldest slot, and the occupancy stays at three. The current top pointer and occupancy are visible on the checkpoint outputs. A branch can record them when it enters the pipeline. If that branch later turns out to be mispredicted, it returns those values on the restore inputs together with the flush strobe, which puts the pointer and count back. The address slots themselves are not rolled back.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `predValid` is low, `ckptTop` is 0 and `ckptCount` is 0.
- R2: A push without a successful pop advances `ckptTop` by one modulo 3 (2 wraps to 0) and raises `ckptCount` by one, saturating at 3.
- R3: With `retPop` high, `retIsCond` low, `flushEn` low and occupancy above zero, `predValid` is high in that same cycle and `predAddr` equals the most recently pushed live address. Without a push, the next cycle shows `ckptTop` moved back by one modulo 3 (0 wraps to 2) and `ckptCount` lowered by one.
- R4: An unconditional pop at zero occupancy gives `predValid` low and leaves `ckptTop` and `ckptCount` unchanged.
- R5: After four pushes A1..A4 starting from empty, pops return A4, A3 and A2 in that order, and the next pop finds the stack empty. A1 has been overwritten.
- R6: A pop with `retIsCond` high gives `predValid` low and changes neither the pointer, the occupancy nor any stored address.
- R7: A push together with a successful unconditional pop predicts the old top address. It then replaces the top slot with `pushAddr` and leaves `ckptTop` and `ckptCount` unchanged.
- R8: A push together with an unconditional pop at zero occupancy gives `predValid` low and behaves as a plain push.
- R9: `flushEn` loads `ckptTop` from `restoreTop` and `ckptCount` from `restoreCount` on the next edge. It overrides any push or pop in the same cycle, forces `predValid` low and leaves the stored addresses untouched.
- R10: `predValid` is low in every cycle in which `retPop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| callPush | input | 1 | Decoded procedure call: push `pushAddr` |
| pushAddr | input | ADDR_W | Return address of the call |
| retPop | input | 1 | Decoded procedure return |
| retIsCond | input | 1 | The return is conditional: no prediction, no pop |
| flushEn | input | 1 | Misprediction restore strobe |
| restoreTop | input | 2 | Top pointer to restore (0..2) |
| restoreCount | input | 2 | Occupancy to restore (0..3) |
| predAddr | output | ADDR_W | Predicted return target, meaningful while `predValid` is high |
| predValid | output | 1 | A return target is being predicted this cycle |
| ckptTop | output | 2 | Current top pointer, for checkpointing |
| ckptCount | output | 2 | Current occupancy, for checkpointing |

## Verification
The assertions take for granted that a restore carries a pointer below 3 and an occupancy no larger than 3, and that `retIsCond` only has meaning while `retPop` is high. The random stimulus respects these limits. It draws restore values only from those ranges, or replays checkpoints it captured earlier from the outputs. Push, pop, condition and flush are drawn with independent weights, so that every combination occurs, including coincident push and pop at empty and full occupancy.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Ring depth is fixed for the block; derived widths follow from it.
  localparam int unsigned RAS_DEPTH = 3;
  localparam int unsigned RAS_PTR_W = $clog2(RAS_DEPTH);
  localparam int unsigned RAS_CNT_W = $clog2(RAS_DEPTH + 1);

  typedef logic [RAS_PTR_W-1:0] ptr_t;
  typedef logic [RAS_CNT_W-1:0] cnt_t;

  localparam ptr_t LAST_SLOT = ptr_t'(RAS_DEPTH - 1);
  localparam cnt_t FULL_CNT  = cnt_t'(RAS_DEPTH);

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_RESTORE
  } ras_op_e;

  // Strobes from control to the address storage.
  typedef struct packed {
    logic writeEn;
    ptr_t writeIdx;
    ptr_t readIdx;
  } ras_strobe_t;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        callPush,
  input  logic        retPop,
  input  logic        retIsCond,
  input  logic        flushEn,
  input  ptr_t        restoreTop,
  input  cnt_t        restoreCount,
  output ras_strobe_t stb,
  output logic        predValid,
  output ptr_t        topPtr,
  output cnt_t        occCount
);
  logic    popReq;
  logic    popHit;
  ptr_t    nextUp;
  ptr_t    nextDown;
  ras_op_e op;

  assign popReq = retPop && !retIsCond;
  assign popHit = popReq && (occCount != '0);

  assign nextUp   = (topPtr == LAST_SLOT) ? '0 : ptr_t'(topPtr + 1'b1);
  assign nextDown = (topPtr == '0) ? LAST_SLOT : ptr_t'(topPtr - 1'b1);

  always_comb begin
    if (flushEn)                op = OP_RESTORE;
    else if (callPush && popHit) op = OP_SWAP;
    else if (callPush)           op = OP_PUSH;
    else if (popHit)             op = OP_POP;
    else                         op = OP_IDLE;
  end

  always_comb begin
    stb.writeEn  = (op == OP_PUSH) || (op == OP_SWAP);
    stb.writeIdx = (op == OP_PUSH) ? nextUp : topPtr;
    stb.readIdx  = topPtr;
  end

  assign predValid = popHit && !flushEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr   <= '0;
      occCount <= '0;
    end else begin
      case (op)
        OP_RESTORE: begin
          topPtr   <= restoreTop;
          occCount <= restoreCount;
        end
        OP_PUSH: begin
          topPtr <= nextUp;
          if (occCount != FULL_CNT) occCount <= cnt_t'(occCount + 1'b1);
        end
        OP_POP: begin
          topPtr   <= nextDown;
          occCount <= cnt_t'(occCount - 1'b1);
        end
        default: ;
      endcase
    end
  end

  // R2: occupancy never exceeds the ring depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= FULL_CNT);

  // R4: an empty unconditional pop moves nothing
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (retPop && !retIsCond && !callPush && !flushEn && occCount == '0)
    |=> ($stable(topPtr) && occCount == '0));

  // R6: a conditional return leaves pointer and count alone
  a_r6_cond_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (retPop && retIsCond && !callPush && !flushEn)
    |=> ($stable(topPtr) && $stable(occCount)));

  // R7: coincident push and hit keep pointer and count
  a_r7_swap_hold: assert property (@(posedge clk) disable iff (!rstN)
    (callPush && retPop && !retIsCond && !flushEn && occCount != '0)
    |=> ($stable(topPtr) && $stable(occCount)));

  // R9: restore loads the supplied checkpoint
  a_r9_restore_load: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> (topPtr == $past(restoreTop) && occCount == $past(restoreCount)));

  // R9: restore values stay in range (input assumption)
  a_r9_restore_range: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |-> (restoreTop <= LAST_SLOT && restoreCount <= FULL_CNT));

  // R10: no prediction without a return strobe
  a_r10_no_pop_no_pred: assert property (@(posedge clk) disable iff (!rstN)
    !retPop |-> !predValid);
endmodule

// File: rtl/ras_datapath.sv
module ras_datapath
  import ras_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ras_strobe_t       stb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] rdData
);
  logic [ADDR_W-1:0] slotVal [RAS_DEPTH];

  for (genvar i = 0; i < RAS_DEPTH; i++) begin : gSlot
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        q <= '0;
      else if (stb.writeEn && stb.writeIdx == ptr_t'(i)) q <= wrData;
    end
    assign slotVal[i] = q;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < RAS_DEPTH; k++) begin
      if (stb.readIdx == ptr_t'(k)) rdData = slotVal[k];
    end
  end

  // R3: control never addresses a slot beyond the ring
  a_r3_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readIdx <= LAST_SLOT) && (!stb.writeEn || stb.writeIdx <= LAST_SLOT));

  // R3: a written slot holds the written address on the next cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |=> (slotVal[$past(stb.writeIdx)] == $past(wrData)));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callPush,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              retPop,
  input  logic              retIsCond,
  input  logic              flushEn,
  input  logic [1:0]        restoreTop,
  input  logic [1:0]        restoreCount,
  output logic [ADDR_W-1:0] predAddr,
  output logic              predValid,
  output logic [1:0]        ckptTop,
  output logic [1:0]        ckptCount
);
  ras_strobe_t stb;
  ptr_t        topPtr;
  cnt_t        occCount;

  ras_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .callPush    (callPush),
    .retPop      (retPop),
    .retIsCond   (retIsCond),
    .flushEn     (flushEn),
    .restoreTop  (ptr_t'(restoreTop)),
    .restoreCount(cnt_t'(restoreCount)),
    .stb         (stb),
    .predValid   (predValid),
    .topPtr      (topPtr),
    .occCount    (occCount)
  );

  ras_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(pushAddr),
    .rdData(predAddr)
  );

  assign ckptTop   = 2'(topPtr);
  assign ckptCount = 2'(occCount);

  // R8: a push with an empty pop still stores and never predicts
  a_r8_empty_swap: assert property (@(posedge clk) disable iff (!rstN)
    (callPush && retPop && !retIsCond && !flushEn && ckptCount == 2'd0)
    |-> !predValid ##1 (ckptCount == 2'd1));
endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          callPush = 1'b0;
  logic [AW-1:0] pushAddr = '0;
  logic          retPop = 1'b0;
  logic          retIsCond = 1'b0;
  logic          flushEn = 1'b0;
  logic [1:0]    restoreTop = '0;
  logic [1:0]    restoreCount = '0;
  logic [AW-1:0] predAddr;
  logic          predValid;
  logic [1:0]    ckptTop;
  logic [1:0]    ckptCount;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench reference state
  logic [AW-1:0] mMem [3];
  int mTop;
  int mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .callPush(callPush), .pushAddr(pushAddr),
    .retPop(retPop), .retIsCond(retIsCond), .flushEn(flushEn),
    .restoreTop(restoreTop), .restoreCount(restoreCount),
    .predAddr(predAddr), .predValid(predValid),
    .ckptTop(ckptTop), .ckptCount(ckptCount)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expHit(input bit r, input bit c, input bit f);
    return r && !c && !f && (mCnt != 0);
  endfunction

  // One decode cycle: drive, check prediction, clock, check state.
  task automatic step(input bit p, input bit r, input bit c, input logic [AW-1:0] a,
                      input bit f, input int ft, input int fc, input string tag);
    bit hitNow;
    bit rawHit;
    @(negedge clk);
    callPush = p; retPop = r; retIsCond = c; pushAddr = a;
    flushEn = f; restoreTop = 2'(ft); restoreCount = 2'(fc);
    #1;
    hitNow = expHit(r, c, f);
    chk(predValid == hitNow, {tag, " predValid"}, AW'(predValid), AW'(hitNow));
    if (!r) chk(predValid == 1'b0, "R10 idle", AW'(predValid), '0);
    if (hitNow) chk(predAddr == mMem[mTop], {tag, " predAddr"}, predAddr, mMem[mTop]);
    rawHit = r && !c && (mCnt != 0);
    @(posedge clk);
    if (f) begin
      mTop = ft; mCnt = fc;
    end else if (p && rawHit) begin
      mMem[mTop] = a;
    end else if (p) begin
      mTop = (mTop == 2) ? 0 : mTop + 1;
      mMem[mTop] = a;
      if (mCnt < 3) mCnt++;
    end else if (rawHit) begin
      mTop = (mTop == 0) ? 2 : mTop - 1;
      mCnt--;
    end
    #1;
    chk(ckptTop == 2'(mTop), {tag, " ckptTop"}, AW'(ckptTop), AW'(mTop));
    chk(ckptCount == 2'(mCnt), {tag, " ckptCount"}, AW'(ckptCount), AW'(mCnt));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sTop;
    int sCnt;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3; i++) mMem[i] = '0;
    mTop = 0; mCnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(predValid == 1'b0, "R1 predValid", AW'(predValid), '0);
    chk(ckptTop == 2'd0, "R1 ckptTop", AW'(ckptTop), '0);
    chk(ckptCount == 2'd0, "R1 ckptCount", AW'(ckptCount), '0);
    @(negedge clk);
    rstN = 1'b1;

    // R4 empty pop
    step(0, 1, 0, '0, 0, 0, 0, "R4");
    // R2 / R5 four pushes wrap
    step(1, 0, 0, 32'hA1, 0, 0, 0, "R2");
    step(1, 0, 0, 32'hA2, 0, 0, 0, "R2");
    step(1, 0, 0, 32'hA3, 0, 0, 0, "R2");
    step(1, 0, 0, 32'hA4, 0, 0, 0, "R5");
    chk(ckptCount == 2'd3, "R2 saturate", AW'(ckptCount), 32'd3);
    // R6 conditional return ignored
    step(0, 1, 1, '0, 0, 0, 0, "R6");
    // R3 / R5 pops in order
    step(0, 1, 0, '0, 0, 0, 0, "R5");
    step(0, 1, 0, '0, 0, 0, 0, "R5");
    step(0, 1, 0, '0, 0, 0, 0, "R3");
    step(0, 1, 0, '0, 0, 0, 0, "R4");
    // R8 push with empty pop
    step(1, 1, 0, 32'hB1, 0, 0, 0, "R8");
    // R7 swap then pop returns new address
    step(1, 1, 0, 32'hB2, 0, 0, 0, "R7");
    step(0, 1, 0, '0, 0, 0, 0, "R7");
    // R9 checkpoint, push, restore over a pop
    step(1, 0, 0, 32'hC1, 0, 0, 0, "R2");
    sTop = ckptTop; sCnt = ckptCount;
    step(1, 0, 0, 32'hC2, 0, 0, 0, "R2");
    step(1, 1, 0, 32'hC3, 1, sTop, sCnt, "R9");
    step(0, 1, 0, '0, 0, 0, 0, "R9");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit p, r, c, f;
      int ft, fc;
      p = ($urandom % 100) < 45;
      r = ($urandom % 100) < 45;
      c = r && (($urandom % 100) < 25);
      f = ($urandom % 100) < 6;
      if (($urandom % 2) == 0) begin
        ft = sTop; fc = sCnt;
      end else begin
        ft = $urandom % 3; fc = $urandom % 4;
      end
      if (($urandom % 16) == 0) begin
        sTop = ckptTop; sCnt = ckptCount;
      end
      step(p, r, c, $urandom, f, ft, fc, "R3 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule